// File: doc/BRIEF.md
# Serial Port Interrupt Identification

This block collects the interrupt causes of a 16550-style serial port and reports them to the host through one identification register and one interrupt line. It supports two views of the same pending state. The legacy view gives a 4-bit code that names the single highest-priority enabled cause. The extended view gives a bitmap with one pending flag per event. The extended flags set whatever the enable register holds.

Every source follows its own rule for clearing. A line error clears when the line status register is read. A receive timeout clears when the receive data port is read. A modem change clears when the modem status register is read. A transmit-low condition clears when the transmit data port is written, or when the legacy code is read while it reports transmit empty. The DMA event clears on any read of the identification register in extended mode. The transmitter-empty event clears when the transmit data port is written. The receive level, the transmit level and the serializer all come from outside the block. The block only turns their strobes and levels into pending state.

The transmit-low tracker is a three-state machine: TX_QUIET, TX_ARMED and TX_ACKED.
- TX_QUIET goes to TX_ARMED when the level rises with no acknowledge in the same cycle.
- TX_QUIET goes to TX_ACKED when the level rises together with an acknowledge.
- TX_ARMED goes to TX_ACKED when it is acknowledged while the level stays high.
- TX_ARMED and TX_ACKED both return to TX_QUIET when the level falls.
- The pending flag is high only in TX_ARMED.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `id_value` reads 8'h01 in legacy mode, `irq` is 0, and the extended bitmap reads 8'h00.
- R2: In legacy mode, `id_value[7:4]` is 0 and `id_value[3:0]` is the code of the highest-priority enabled source. From highest to lowest, the codes are:
  - 0110 for a line error, enabled by `ier[2]`.
  - 1100 for a receive timeout, enabled by `ier[0]`.
  - 0100 for receive level high, enabled by `ier[0]`.
  - 0010 for transmit low, enabled by `ier[1]`.
  - 0000 for a modem change, enabled by `ier[3]`.
  - 0001 when no enabled source is pending.
- R3: A pulse on `line_err_evt` makes the line error pending from the next cycle. Only `rd_lsr` clears it; an identification read leaves it set.
- R4: Receive level high follows `rx_level_hi` directly. A pulse on `rx_timeout_evt` makes the timeout pending until `rd_rx`.
- R5: Transmit low becomes pending on a rising edge of `tx_low`. It clears on `wr_tx`. It also clears on `rd_id` in legacy mode, but only while the code reads 0010. Once cleared, it stays clear until `tx_low` falls and rises again.
- R6: A pulse on any bit of `ms_delta` makes the modem change pending until `rd_msr`.
- R7: In extended mode, `id_value` is a bitmap that does not depend on `ier`. Bits 7 and 6 read 0. The other bits are:
  - bit 0: receive level.
  - bit 1: transmit low.
  - bit 2: line error.
  - bit 3: modem change.
  - bit 4: DMA event.
  - bit 5: transmitter-empty event.
- R8: In extended mode, `rd_id` clears only the DMA flag (bit 4). In legacy mode, `rd_id` leaves the DMA flag set.
- R9: Extended bit 0 is `rx_level_hi` OR'ed with the pending timeout only when `fifo_en` is 1. With `fifo_en` at 0, a pending timeout does not show in bit 0.
- R10: In extended mode, `irq` is the OR of bitmap bits 5..0, each ANDed with the matching `ier` bit. In legacy mode, `irq` is 1 exactly when the code is not 0001.
- R11: When a set event and its clear access arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 selects the extended bitmap view |
| fifo_en | input | 1 | FIFOs enabled |
| ier | input | 6 | Per-source enable bits |
| line_err_evt | input | 1 | Parity, framing, overrun or break pulse |
| rx_level_hi | input | 1 | Holding register full or receive level at or above threshold |
| rx_timeout_evt | input | 1 | Receive timeout pulse |
| tx_low | input | 1 | Transmit holding register empty or level below threshold |
| tx_shift_empty_evt | input | 1 | Transmitter-empty pulse |
| dma_evt | input | 1 | DMA event pulse |
| ms_delta | input | MS_W | Modem status change pulses |
| rd_id | input | 1 | Identification register read |
| rd_lsr | input | 1 | Line status register read |
| rd_msr | input | 1 | Modem status register read |
| rd_rx | input | 1 | Receive data port read |
| wr_tx | input | 1 | Transmit data port write |
| id_value | output | ID_W | Identification register value |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 4-bit modem change field and an 8-bit identification register. With only seven event inputs, the bench can sweep every combination of pending sources, which is 128 patterns. It runs that sweep under four enable patterns and checks both views after each one. Directed sequences then cover the ordering cases:
- acknowledging transmit low through an identification read only when it is top priority;
- re-arming transmit low only on a new rising edge;
- a set and a clear arriving in the same cycle;
- DMA-only clearing in extended mode;
- timeout masking in bit 0 when the FIFOs are disabled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    typedef enum logic [1:0] {
        TX_QUIET = 2'd0,
        TX_ARMED = 2'd1,
        TX_ACKED = 2'd2
    } tx_state_e;

    localparam logic [3:0] CODE_NONE  = 4'b0001;
    localparam logic [3:0] CODE_LINE  = 4'b0110;
    localparam logic [3:0] CODE_RXLVL = 4'b0100;
    localparam logic [3:0] CODE_RXTO  = 4'b1100;
    localparam logic [3:0] CODE_TX    = 4'b0010;
    localparam logic [3:0] CODE_MODEM = 4'b0000;

    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int EN_DMA   = 4;
    localparam int EN_TXEMP = 5;
    localparam int EN_W     = 6;
endpackage

// File: rtl/irq_sticky.sv
module irq_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (set[i]) begin
                q[i] <= 1'b1;
            end else if (clr[i]) begin
                q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_tx_tracker.sv
module irq_tx_tracker
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic ack,
    output logic pending
);
    tx_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_QUIET;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_QUIET: if (level) nxt = ack ? TX_ACKED : TX_ARMED;
            TX_ARMED: begin
                if (!level) begin
                    nxt = TX_QUIET;
                end else if (ack) begin
                    nxt = TX_ACKED;
                end
            end
            TX_ACKED: if (!level) nxt = TX_QUIET;
            default:  nxt = TX_QUIET;
        endcase
    end

    always_comb begin
        pending = (state == TX_ARMED);
    end
endmodule

// File: rtl/irq_legacy_encode.sv
module irq_legacy_encode
    import uart_irq_pkg::*;
(
    input  logic       line_on,
    input  logic       rxto_on,
    input  logic       rxlvl_on,
    input  logic       tx_on,
    input  logic       modem_on,
    output logic [3:0] code
);
    always_comb begin
        if (line_on) begin
            code = CODE_LINE;
        end else if (rxto_on) begin
            code = CODE_RXTO;
        end else if (rxlvl_on) begin
            code = CODE_RXLVL;
        end else if (tx_on) begin
            code = CODE_TX;
        end else if (modem_on) begin
            code = CODE_MODEM;
        end else begin
            code = CODE_NONE;
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int MS_W = 4,
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_mode,
    input  logic            fifo_en,
    input  logic [EN_W-1:0] ier,
    input  logic            line_err_evt,
    input  logic            rx_level_hi,
    input  logic            rx_timeout_evt,
    input  logic            tx_low,
    input  logic            tx_shift_empty_evt,
    input  logic            dma_evt,
    input  logic [MS_W-1:0] ms_delta,
    input  logic            rd_id,
    input  logic            rd_lsr,
    input  logic            rd_msr,
    input  logic            rd_rx,
    input  logic            wr_tx,
    output logic [ID_W-1:0] id_value,
    output logic            irq
);
    localparam int SF_LINE  = 0;
    localparam int SF_RXTO  = 1;
    localparam int SF_DMA   = 2;
    localparam int SF_TXEMP = 3;
    localparam int SF_MS0   = 4;
    localparam int SF_W     = SF_MS0 + MS_W;

    logic [SF_W-1:0] sf_set, sf_clr, sf_q;
    logic            modem_pend;
    logic            tx_pend;
    logic            tx_ack;
    logic [3:0]      code;
    logic [EN_W-1:0] bitmap;

    always_comb begin
        sf_set = '0;
        sf_clr = '0;
        sf_set[SF_LINE]  = line_err_evt;
        sf_clr[SF_LINE]  = rd_lsr;
        sf_set[SF_RXTO]  = rx_timeout_evt;
        sf_clr[SF_RXTO]  = rd_rx;
        sf_set[SF_DMA]   = dma_evt;
        sf_clr[SF_DMA]   = rd_id & ext_mode;
        sf_set[SF_TXEMP] = tx_shift_empty_evt;
        sf_clr[SF_TXEMP] = wr_tx;
        sf_set[SF_W-1:SF_MS0] = ms_delta;
        sf_clr[SF_W-1:SF_MS0] = {MS_W{rd_msr}};
    end

    irq_sticky #(.W(SF_W)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (sf_set),
        .clr   (sf_clr),
        .q     (sf_q)
    );

    assign modem_pend = |sf_q[SF_W-1:SF_MS0];

    irq_legacy_encode u_encode (
        .line_on  (sf_q[SF_LINE] & ier[EN_LINE]),
        .rxto_on  (sf_q[SF_RXTO] & ier[EN_RX]),
        .rxlvl_on (rx_level_hi & ier[EN_RX]),
        .tx_on    (tx_pend & ier[EN_TX]),
        .modem_on (modem_pend & ier[EN_MODEM]),
        .code     (code)
    );

    assign tx_ack = wr_tx | (rd_id & ~ext_mode & (code == CODE_TX));

    irq_tx_tracker u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (tx_low),
        .ack     (tx_ack),
        .pending (tx_pend)
    );

    always_comb begin
        bitmap = '0;
        bitmap[EN_RX]    = rx_level_hi | (fifo_en & sf_q[SF_RXTO]);
        bitmap[EN_TX]    = tx_pend;
        bitmap[EN_LINE]  = sf_q[SF_LINE];
        bitmap[EN_MODEM] = modem_pend;
        bitmap[EN_DMA]   = sf_q[SF_DMA];
        bitmap[EN_TXEMP] = sf_q[SF_TXEMP];
    end

    always_comb begin
        id_value = '0;
        if (ext_mode) begin
            id_value[EN_W-1:0] = bitmap;
            irq = |(bitmap & ier);
        end else begin
            id_value[3:0] = code;
            irq = (sf_q[SF_LINE] & ier[EN_LINE])
                | ((sf_q[SF_RXTO] | rx_level_hi) & ier[EN_RX])
                | (tx_pend & ier[EN_TX])
                | (modem_pend & ier[EN_MODEM]);
        end
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int MS_W = 4,
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ext_mode,
    input logic [5:0]      ier,
    input logic            line_err_evt,
    input logic            tx_low,
    input logic            dma_evt,
    input logic [MS_W-1:0] ms_delta,
    input logic            rd_id,
    input logic            rd_lsr,
    input logic            rd_msr,
    input logic            wr_tx,
    input logic [ID_W-1:0] id_value,
    input logic            irq
);
    assert_legacy_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && !irq) |-> (id_value[3:0] == 4'b0001));

    assert_legacy_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && irq) |-> (id_value[ID_W-1:4] == '0 && id_value[3:0] != 4'b0001));

    assert_line_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_err_evt |=> (!ext_mode || id_value[2]));

    assert_line_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !line_err_evt) |=> (!ext_mode || !id_value[2]));

    assert_tx_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_low) && tx_low && wr_tx) |=> (!ext_mode || !id_value[1]));

    assert_modem_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_msr && ms_delta == '0) |=> (!ext_mode || !id_value[3]));

    assert_ext_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> (id_value[ID_W-1:6] == '0));

    assert_dma_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && rd_id && !dma_evt) |=> (!ext_mode || !id_value[4]));

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 6'd0) |-> !irq);

    assert_line_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err_evt && rd_lsr) |=> (!ext_mode || id_value[2]));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.MS_W(MS_W), .ID_W(ID_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_mode     (ext_mode),
    .ier          (ier),
    .line_err_evt (line_err_evt),
    .tx_low       (tx_low),
    .dma_evt      (dma_evt),
    .ms_delta     (ms_delta),
    .rd_id        (rd_id),
    .rd_lsr       (rd_lsr),
    .rd_msr       (rd_msr),
    .wr_tx        (wr_tx),
    .id_value     (id_value),
    .irq          (irq)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_mode = 1'b0, fifo_en = 1'b1;
    logic [5:0] ier = 6'h3f;
    logic       line_err_evt = 1'b0, rx_level_hi = 1'b0, rx_timeout_evt = 1'b0;
    logic       tx_low = 1'b0, tx_shift_empty_evt = 1'b0, dma_evt = 1'b0;
    logic [3:0] ms_delta = 4'd0;
    logic       rd_id = 1'b0, rd_lsr = 1'b0, rd_msr = 1'b0, rd_rx = 1'b0, wr_tx = 1'b0;
    logic [7:0] id_value;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    uart_irq_ident i_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .fifo_en(fifo_en), .ier(ier),
        .line_err_evt(line_err_evt), .rx_level_hi(rx_level_hi),
        .rx_timeout_evt(rx_timeout_evt), .tx_low(tx_low),
        .tx_shift_empty_evt(tx_shift_empty_evt), .dma_evt(dma_evt), .ms_delta(ms_delta),
        .rd_id(rd_id), .rd_lsr(rd_lsr), .rd_msr(rd_msr), .rd_rx(rd_rx), .wr_tx(wr_tx),
        .id_value(id_value), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_code(input logic [6:0] m, input logic [5:0] en);
        if (m[0] && en[2])      return 4'b0110;
        else if (m[2] && en[0]) return 4'b1100;
        else if (m[1] && en[0]) return 4'b0100;
        else if (m[3] && en[1]) return 4'b0010;
        else if (m[4] && en[3]) return 4'b0000;
        else                    return 4'b0001;
    endfunction

    function automatic logic [7:0] exp_map(input logic [6:0] m, input logic fe);
        return {2'b00, m[6], m[5], m[4], m[0], m[3], m[1] | (fe & m[2])};
    endfunction

    task automatic drop_strobes();
        line_err_evt = 0; rx_timeout_evt = 0; tx_shift_empty_evt = 0; dma_evt = 0;
        ms_delta = 0; rd_id = 0; rd_lsr = 0; rd_msr = 0; rd_rx = 0; wr_tx = 0;
    endtask

    task automatic next_cycle();
        @(negedge clk);
        drop_strobes();
    endtask

    task automatic flush();
        @(negedge clk);
        ext_mode = 1; rx_level_hi = 0; tx_low = 0;
        rd_id = 1; rd_lsr = 1; rd_msr = 1; rd_rx = 1; wr_tx = 1;
        next_cycle();
        ext_mode = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 legacy id", id_value, 8'h01);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        ext_mode = 1; #1;
        chk("R1 bitmap", id_value, 8'h00);
        ext_mode = 0;

        // R2 R4 R7 R9 R10 sweep of every pending pattern
        for (int e = 0; e < 4; e++) begin
            logic [5:0] en;
            en = (e == 0) ? 6'h3f : (e == 1) ? 6'h00 : (e == 2) ? 6'h15 : 6'h2a;
            for (int m = 0; m < 128; m++) begin
                logic [6:0] mv;
                logic [7:0] em;
                mv = m[6:0];
                @(negedge clk);
                ier = en; line_err_evt = mv[0]; rx_level_hi = mv[1]; rx_timeout_evt = mv[2];
                tx_low = mv[3]; ms_delta = mv[4] ? 4'b1000 : 4'b0000; dma_evt = mv[5];
                tx_shift_empty_evt = mv[6];
                next_cycle();
                ext_mode = 0; #1;
                chk("R2 legacy code", id_value, {4'b0000, exp_code(mv, en)});
                chk("R10 legacy irq", {7'd0, irq}, {7'd0, exp_code(mv, en) != 4'b0001});
                ext_mode = 1; #1;
                em = exp_map(mv, 1'b1);
                chk("R7 bitmap", id_value, em);
                chk("R10 ext irq", {7'd0, irq}, {7'd0, |(em[5:0] & en)});
                ext_mode = 0;
                flush();
            end
        end
        ier = 6'h3f;

        // R5 R3: identification read acknowledges transmit low only when on top
        @(negedge clk); line_err_evt = 1; tx_low = 1;
        next_cycle();
        chk("R3 line on top", id_value, 8'h06);
        rd_id = 1; next_cycle();
        chk("R3 id read keeps line", id_value, 8'h06);
        rd_lsr = 1; next_cycle();
        chk("R5 tx now on top", id_value, 8'h02);
        rd_id = 1; next_cycle();
        chk("R5 tx acked by id read", id_value, 8'h01);
        repeat (2) next_cycle();
        chk("R5 no rearm while level stays", id_value, 8'h01);
        tx_low = 0; next_cycle();
        tx_low = 1; next_cycle();
        chk("R5 rearm on new rising edge", id_value, 8'h02);
        wr_tx = 1; next_cycle();
        chk("R5 write acks tx", id_value, 8'h01);
        flush();

        // R11 set and clear together
        @(negedge clk); line_err_evt = 1; rd_lsr = 1;
        next_cycle();
        chk("R11 set wins", id_value, 8'h06);
        flush();

        // R8 extended identification read clears DMA only
        @(negedge clk); ext_mode = 1; dma_evt = 1; tx_low = 1; line_err_evt = 1;
        next_cycle();
        chk("R8 before read", id_value, 8'h16);
        rd_id = 1; next_cycle();
        chk("R8 only DMA cleared", id_value, 8'h06);
        ext_mode = 0; dma_evt = 1; next_cycle();
        rd_id = 1; next_cycle();
        ext_mode = 1; #1;
        chk("R8 legacy read keeps DMA", id_value[4], 1'b1);
        ext_mode = 0;
        flush();

        // R6 each modem change bit
        for (int b = 0; b < 4; b++) begin
            @(negedge clk); ext_mode = 1; ms_delta = 4'b0001 << b;
            next_cycle();
            chk("R6 modem bit set", id_value, 8'h08);
            rd_msr = 1; next_cycle();
            chk("R6 modem cleared", id_value, 8'h00);
        end
        ext_mode = 0;

        // R9 FIFOs disabled hide the timeout from bit 0; R4 cleared by rx read
        @(negedge clk); fifo_en = 0; ext_mode = 1; rx_timeout_evt = 1;
        next_cycle();
        chk("R9 timeout hidden", id_value, 8'h00);
        ext_mode = 0; #1;
        chk("R4 timeout code", id_value, 8'h0c);
        fifo_en = 1; ext_mode = 1; #1;
        chk("R9 timeout shown", id_value, 8'h01);
        rd_rx = 1; next_cycle();
        chk("R4 timeout cleared", id_value, 8'h00);
        ext_mode = 0;

        finish_run();
    end
endmodule